// File: doc/BRIEF.md
# Polarity-Configurable Level Interrupt Controller

This block collects 32 level-sensitive interrupt sources and folds them into one cascade request line for an upstream interrupt controller. Every source is first brought into the local clock domain, then adjusted by its own polarity bit, so that a source can count as asserted when its line is high or when it is low. An asserted source sets a sticky bit in a pending register. That bit stays set until software clears it by writing a one to it. A per-source enable mask decides which pending bits can raise the cascade line.

Software reaches the block through a plain 32-bit register port: byte address, write strobe, write data and registered read data. The per-source registers number the sources from the most significant bit down, so source n occupies register bit 31-n. The port input `src_lvl` is indexed by source number. The raw synchronised levels can be read back separately, before polarity correction. A general 32-bit read/write word is also provided for accumulated-status gating. The interrupt service loop reads the pending word, handles each source and writes ones to acknowledge it. Masking and unmasking are done with read-modify-write of the enable word.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending, enable, polarity and accumulated-enable registers are all zero, and `irq_out` is low.
- R2: Source n (`src_lvl[n]`) appears at bit 31-n of the pending, enable, polarity and raw registers.
- R3: A polarity bit of 0 treats a high level as asserted. A polarity bit of 1 treats a low level as asserted. Any asserted source sets its pending bit (offset 0x50).
- R4: In the pending register, bits written with 1 are cleared and bits written with 0 keep their value. A pending bit stays set after its source deasserts.
- R5: When a source is still asserted in the cycle its pending bit is cleared, the bit stays set, because setting wins over clearing.
- R6: The enable (0x54), polarity (0x58) and accumulated-enable (0x04) registers read back exactly the last value written.
- R7: The raw register (0x5C) returns the synchronised input levels without polarity correction. Writes to it have no effect.
- R8: `irq_out` is the OR over all bits of (pending AND enable), registered one cycle after the enable/pending state. It is low whenever every enable bit is zero.
- R9: A masked source still sets its pending bit.
- R10: Reads of any offset other than 0x04, 0x50, 0x54, 0x58 and 0x5C return zero. Writes to such offsets change no register.
- R11: Read data appears on `rd_data` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, commits `wr_data` at the clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |
| src_lvl | input | 32 | Interrupt source levels, index = source number, asynchronous |
| irq_out | output | 1 | Registered cascade request |

## Verification
The assertions assume that reset is held for at least two clock edges, so that every register has a defined previous value when checking begins. They also assume that `addr` and `wr_en` are driven to known values in every cycle. The bench drives all inputs on the falling edge and keeps reset high for several cycles. After each change of `src_lvl` it waits more than the synchroniser depth plus the latch and output stages before it samples pending or raw state. Reads hold the address for a full cycle, matching the one-cycle registered read path.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned OFS_W  = 8;
  // offsets are decoded by the software driver and must stay fixed
  localparam logic [OFS_W-1:0] OFS_ACC  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h50;
  localparam logic [OFS_W-1:0] OFS_EN   = 8'h54;
  localparam logic [OFS_W-1:0] OFS_POL  = 8'h58;
  localparam logic [OFS_W-1:0] OFS_RAW  = 8'h5C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ACC, SEL_STAT, SEL_EN, SEL_POL, SEL_RAW
  } reg_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lvl_irq_latch.sv
module lvl_irq_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] status,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq_o  <= 1'b0;
    end else begin
      status <= (status & ~clr) | hit;
      irq_o  <= |(status & en);
    end
  end

  // R4: uncleared pending bits never drop
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(status) & ~$past(clr))) & ~status) == '0));
  // R5 / R9: an asserted source is pending next cycle, regardless of clear or mask
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit) & ~status) == '0));
  // R8: request only follows an enabled pending bit
  p_out_src_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(status & en)));
  // R8: all masked keeps the line low
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(en) == '0) |-> !irq_o);
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      clr,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] acc_q;
  reg_sel_e     sel;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_ACC))  sel = SEL_ACC;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
    else if (addr == ADDR_W'(OFS_POL))  sel = SEL_POL;
    else if (addr == ADDR_W'(OFS_RAW))  sel = SEL_RAW;
  end

  assign clr = (wr_en && sel == SEL_STAT) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
      acc_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_EN:  en_q  <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_ACC: acc_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (sel)
        SEL_ACC:  rd_data <= acc_q;
        SEL_STAT: rd_data <= status;
        SEL_EN:   rd_data <= en_q;
        SEL_POL:  rd_data <= pol_q;
        SEL_RAW:  rd_data <= raw;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R6: a write to the enable word is what it holds next
  p_en_back_r6: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr == ADDR_W'(OFS_EN)) |-> (en_q == $past(wr_data)));
  // R10: unmapped reads give zero one cycle later
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (addr != ADDR_W'(OFS_ACC) && addr != ADDR_W'(OFS_STAT) &&
     addr != ADDR_W'(OFS_EN)  && addr != ADDR_W'(OFS_POL) &&
     addr != ADDR_W'(OFS_RAW)) |=> (rd_data == '0));
  // R10: unmapped writes leave enable and polarity alone
  p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != ADDR_W'(OFS_EN) && addr != ADDR_W'(OFS_POL))
      |=> ($stable(en_q) && $stable(pol_q)));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NSRC      = REG_W,
  parameter int unsigned ADDR_W    = OFS_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NSRC-1:0]   wr_data,
  output logic [NSRC-1:0]   rd_data,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              irq_out
);
  logic [NSRC-1:0] src_rev, lvl_s, hit, en_q, pol_q, clr, status;

  // source n lands on register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_rev
    assign src_rev[NSRC-1-n] = src_lvl[n];
  end

  lvl_irq_sync #(.W(NSRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(src_rev), .q(lvl_s)
  );

  assign hit = lvl_s ^ pol_q;

  lvl_irq_latch #(.W(NSRC)) u_latch (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .en(en_q),
    .status(status), .irq_o(irq_out)
  );

  lvl_irq_regs #(.W(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .raw(lvl_s), .en_q(en_q), .pol_q(pol_q),
    .clr(clr), .rd_data(rd_data)
  );

  // R3: with no pending work and nothing asserted, nothing becomes pending
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (status == '0 && (lvl_s ^ pol_q) == '0) |=> (status == '0));
endmodule

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
  import lvl_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] src_lvl = '0;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lvl_irq_ctrl uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_lvl(src_lvl), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] pol;
    logic [31:0] en;
    logic [31:0] exp_st;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0},
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b1},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{32'h0000_00F0, 32'h0000_0000, 32'h0100_0000, 32'h0F00_0000, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001, 1'b1},
    '{32'hFFFF_0000, 32'h00FF_0000, 32'hFF00_0000, 32'h00FF_FFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(OFS_STAT, v); chk("R1 status", v, 32'h0);
    rd(OFS_EN, v);   chk("R1 enable", v, 32'h0);
    rd(OFS_POL, v);  chk("R1 polarity", v, 32'h0);
    rd(OFS_ACC, v);  chk("R1 acc", v, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);

    // R2 R3 R8 R9 table
    for (int i = 0; i < 6; i++) begin
      wr(OFS_POL, VECS[i].pol);
      wr(OFS_EN, VECS[i].en);
      src_lvl = VECS[i].src;
      idle(5);
      wr(OFS_STAT, 32'hFFFF_FFFF);
      idle(4);
      rd(OFS_STAT, v);
      chk("R2 R3 pending", v, VECS[i].exp_st);
      chk("R8 R9 irq", {31'b0, irq_out}, {31'b0, VECS[i].exp_irq});
    end

    wr(OFS_POL, 32'h0); wr(OFS_EN, 32'h0); src_lvl = '0;
    idle(4); wr(OFS_STAT, 32'hFFFF_FFFF);

    // R4 sticky and write-one-to-clear
    src_lvl = 32'h0000_0003; idle(5); src_lvl = '0; idle(4);
    rd(OFS_STAT, v); chk("R4 sticky", v, 32'hC000_0000);
    wr(OFS_STAT, 32'h4000_0000);
    rd(OFS_STAT, v); chk("R4 clear one", v, 32'h8000_0000);
    wr(OFS_STAT, 32'h0);
    rd(OFS_STAT, v); chk("R4 zero write", v, 32'h8000_0000);
    wr(OFS_STAT, 32'hFFFF_FFFF);
    rd(OFS_STAT, v); chk("R4 clear all", v, 32'h0);

    // R5 set beats clear
    src_lvl = 32'h0000_0004; idle(5);
    wr(OFS_STAT, 32'h2000_0000);
    rd(OFS_STAT, v); chk("R5 relatch", v, 32'h2000_0000);
    src_lvl = '0; idle(4); wr(OFS_STAT, 32'hFFFF_FFFF);

    // R7 raw levels
    src_lvl = 32'h0000_0003;
    wr(OFS_POL, 32'hFFFF_FFFF); idle(5);
    rd(OFS_RAW, v); chk("R7 raw", v, 32'hC000_0000);
    wr(OFS_RAW, 32'h1234_5678);
    rd(OFS_RAW, v); chk("R7 raw readonly", v, 32'hC000_0000);
    wr(OFS_POL, 32'h0); src_lvl = '0; idle(4);
    wr(OFS_STAT, 32'hFFFF_FFFF);

    // R6 readback
    wr(OFS_EN, 32'hA5A5_A5A5);
    rd(OFS_EN, v); chk("R6 enable", v, 32'hA5A5_A5A5);
    wr(OFS_ACC, 32'hDEAD_BEEF);
    rd(OFS_ACC, v); chk("R6 acc", v, 32'hDEAD_BEEF);
    wr(OFS_POL, 32'h0F0F_0000);
    rd(OFS_POL, v); chk("R6 polarity", v, 32'h0F0F_0000);
    wr(OFS_POL, 32'h0); idle(4);

    // R10 unmapped
    rd(8'h00, v); chk("R10 read 0x00", v, 32'h0);
    rd(8'h60, v); chk("R10 read 0x60", v, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(OFS_EN, v);  chk("R10 enable intact", v, 32'hA5A5_A5A5);
    rd(OFS_ACC, v); chk("R10 acc intact", v, 32'hDEAD_BEEF);

    // R8 R11 timing
    wr(OFS_EN, 32'h0); wr(OFS_STAT, 32'hFFFF_FFFF);
    src_lvl = 32'h0000_0001; idle(5);
    chk("R8 all masked", {31'b0, irq_out}, 32'h0);
    wr(OFS_EN, 32'h8000_0000); idle(3);
    chk("R8 raised", {31'b0, irq_out}, 32'h1);
    wr(OFS_EN, 32'h0);
    chk("R8 one-cycle lag", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R8 dropped", {31'b0, irq_out}, 32'h0);
    // R11: address presented, data one edge later
    @(negedge clk); addr = OFS_STAT;
    @(negedge clk); chk("R11 read latency", rd_data, 32'h8000_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule